// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by reading a radix tree of translation tables held in memory. A requester hands over one address at a time, together with a write flag and a user/supervisor flag. The walker then reads one 64-bit entry per level through a single request/response memory port. The walk runs from the top directory down to the leaf table. Each entry is checked on the way. The walk ends with either the translated address or a fault that names the level where it stopped.

The top table's base comes from a root register. Software loads this register to switch to a different set of tables. A load that arrives while a walk is in flight is parked. It is committed in the first idle cycle after that walk, so one translation never mixes two table sets.

Table entries are 64 bits wide. Bit 0 marks the entry present, bit 1 allows writes and bit 2 allows user access. Bits [51:12] give the 4 KiB-aligned base of the next table, or of the final frame. The upper half of the virtual space, where vaddr[47] is 1, belongs to the kernel.

Top module: `pgwalk`

## Requirements
- R1: A successful translation issues exactly four memory reads and returns the leaf entry's bits [51:12] as paddr[51:12], with vaddr[11:0] passed unchanged as paddr[11:0].
- R2: Level L (0 to 3) is indexed by vaddr[47-9L:39-9L]. Each read address is the current table base plus index*8. The first base is the root register, and each later base is the previous entry's bits [51:12] shifted left by 12.
- R3: An entry with bit 0 clear at level L ends the walk with a fault reporting level L. No further reads are issued, and the reported paddr is zero.
- R4: For a user-mode request, an entry with bit 2 clear at level L faults at level L. Supervisor requests ignore bit 2.
- R5: For a write request, an entry with bit 1 clear at level L faults at level L. This holds in both modes.
- R6: A user-mode request with vaddr[47]=1 faults at level 0 without any memory read. A supervisor request in that region is walked normally.
- R7: A root write in an idle cycle takes effect for every later translation. This includes a request accepted in the same cycle.
- R8: A root write during a walk does not change that walk. It is held, reqReady stays low until it is committed, and it is committed in the first idle cycle.
- R9: At most one memory read is outstanding, and each read request is a one-cycle pulse. Every accepted request gets exactly one one-cycle response.
- R10: After reset, reqReady is 1, memReqValid and rspValid are 0, and the root register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWrEn | input | 1 | Load strobe for the root register |
| rootWrData | input | 52 | New top-table base; bits [11:0] ignored |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can accept a request this cycle |
| reqVaddr | input | 48 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write access |
| reqUser | input | 1 | Request comes from user mode |
| memReqValid | output | 1 | One-cycle read request to table memory |
| memReqAddr | output | 52 | Physical address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Table entry read from memory |
| rspValid | output | 1 | One-cycle translation result strobe |
| rspPaddr | output | 52 | Translated physical address (zero on fault) |
| rspFault | output | 1 | Translation faulted |
| rspFaultLevel | output | 2 | Level where the walk stopped on a fault |

## Verification
The assertions assume the memory side answers each read exactly once. They also assume it never raises memRspValid unless the walker is waiting on a read it issued. They do not assume a fixed memory latency. The bench's table memory follows this contract: it latches each read request and answers it on the next cycle. Root writes may arrive at any time, including mid-walk, and the bench does exactly that. No sequence in the bench sends a response without a request.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // Default geometry of the translation tree.
  localparam int unsigned PG_LEVELS = 4;
  localparam int unsigned PG_IDX_W  = 9;
  localparam int unsigned PG_OFF_W  = 12;
  localparam int unsigned PG_PA_W   = 52;
  localparam int unsigned PG_PTE_W  = 64;

  // Entry flag positions decoded by the datapath.
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_WRITE   = 1;
  localparam int unsigned PTE_USER    = 2;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic idle;       // walker idle: root may be committed
    logic capture;    // latch incoming request, load base from root
    logic issue;      // drive a memory read this cycle
    logic step;       // descend: base <= entry base
    logic doneOk;     // load translated address
    logic doneFault;  // load fault result
  } walkCtl_t;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2,
    W_DONE  = 2'd3
  } walkState_e;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int unsigned LEVELS = PG_LEVELS,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned CNT_W = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memRspValid,
  input  logic             kernelUser,
  input  logic             entryBad,
  input  logic             rootPending,
  output walkCtl_t         ctl,
  output logic [LVL_W-1:0] lvl,
  output logic             reqReady,
  output logic             memReqValid,
  output logic             rspValid
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walkState_e       stateQ, stateD;
  logic [LVL_W-1:0] lvlQ, lvlD;
  logic             accept;

  assign reqReady    = (stateQ == W_IDLE) && !rootPending;
  assign accept      = reqValid && reqReady;
  assign memReqValid = (stateQ == W_ISSUE);
  assign rspValid    = (stateQ == W_DONE);
  assign lvl         = lvlQ;

  always_comb begin
    stateD        = stateQ;
    lvlD          = lvlQ;
    ctl           = '0;
    ctl.idle      = (stateQ == W_IDLE);
    ctl.issue     = (stateQ == W_ISSUE);
    unique case (stateQ)
      W_IDLE: begin
        if (accept) begin
          ctl.capture = 1'b1;
          if (kernelUser) begin
            ctl.doneFault = 1'b1;
            stateD        = W_DONE;
          end else begin
            stateD = W_ISSUE;
          end
        end
      end
      W_ISSUE: stateD = W_WAIT;
      W_WAIT: begin
        if (memRspValid) begin
          if (entryBad) begin
            ctl.doneFault = 1'b1;
            stateD        = W_DONE;
          end else if (lvlQ == LAST_LVL) begin
            ctl.doneOk = 1'b1;
            stateD     = W_DONE;
          end else begin
            ctl.step = 1'b1;
            lvlD     = lvlQ + 1'b1;
            stateD   = W_ISSUE;
          end
        end
      end
      W_DONE: begin
        lvlD   = '0;
        stateD = W_IDLE;
      end
      default: stateD = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= W_IDLE;
      lvlQ   <= '0;
    end else begin
      stateQ <= stateD;
      lvlQ   <= lvlD;
    end
  end

  // Checker state: reads issued in the current walk and its outcome.
  logic [CNT_W-1:0] readCntQ;
  logic             okQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCntQ <= '0;
      okQ      <= 1'b0;
    end else begin
      if (ctl.capture)      readCntQ <= '0;
      else if (memReqValid) readCntQ <= readCntQ + 1'b1;
      if (ctl.doneOk)        okQ <= 1'b1;
      else if (ctl.capture)  okQ <= 1'b0;
    end
  end

  // R9
  mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9 (input contract: data only arrives for an outstanding read)
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (stateQ == W_WAIT));

  // R1
  full_walk_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && okQ) |-> (readCntQ == CNT_W'(LEVELS)));

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int unsigned LEVELS = PG_LEVELS,
  parameter int unsigned IDX_W  = PG_IDX_W,
  parameter int unsigned OFF_W  = PG_OFF_W,
  parameter int unsigned PA_W   = PG_PA_W,
  parameter int unsigned PTE_W  = PG_PTE_W,
  localparam int unsigned VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  walkCtl_t         ctl,
  input  logic [LVL_W-1:0] lvl,
  input  logic             rootWrEn,
  input  logic [PA_W-1:0]  rootWrData,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [PTE_W-1:0] memRspData,
  output logic             kernelUser,
  output logic             entryBad,
  output logic             rootPending,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspFault,
  output logic [LVL_W-1:0] rspFaultLevel
);

  localparam int unsigned FRM_W = PA_W - OFF_W;

  logic [VA_W-1:0]  vaQ;
  logic             wrQ, usrQ;
  logic [PA_W-1:0]  baseQ, rootQ, pendValQ;
  logic             pendQ;
  logic [PA_W-1:0]  paQ;
  logic             faultQ;
  logic [LVL_W-1:0] fLvlQ;

  // Per-level index slices, top level first.
  logic [IDX_W-1:0] idxArr [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxArr[g] = vaQ[OFF_W + IDX_W * (LEVELS - 1 - g) +: IDX_W];
  end

  logic [FRM_W-1:0] entFrame;
  logic [PA_W-1:0]  entBase, rootEff;
  logic             entPresent, entWrite, entUser;

  assign entFrame   = memRspData[PA_W-1:OFF_W];
  assign entBase    = {entFrame, {OFF_W{1'b0}}};
  assign entPresent = memRspData[PTE_PRESENT];
  assign entWrite   = memRspData[PTE_WRITE];
  assign entUser    = memRspData[PTE_USER];

  assign entryBad   = !entPresent || (usrQ && !entUser) || (wrQ && !entWrite);
  assign kernelUser = reqUser && reqVaddr[VA_W-1];
  assign memReqAddr = baseQ + (PA_W'(idxArr[lvl]) << 3);
  assign rootEff    = rootWrEn ? {rootWrData[PA_W-1:OFF_W], {OFF_W{1'b0}}} : rootQ;

  assign rootPending   = pendQ;
  assign rspPaddr      = paQ;
  assign rspFault      = faultQ;
  assign rspFaultLevel = fLvlQ;

  logic unusedBits;
  assign unusedBits = ^{memRspData[PTE_W-1:PA_W], memRspData[OFF_W-1:PTE_USER+1],
                        rootWrData[OFF_W-1:0]};

  // Request capture and walk base.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ   <= '0;
      wrQ   <= 1'b0;
      usrQ  <= 1'b0;
      baseQ <= '0;
    end else if (ctl.capture) begin
      vaQ   <= reqVaddr;
      wrQ   <= reqWrite;
      usrQ  <= reqUser;
      baseQ <= rootEff;
    end else if (ctl.step) begin
      baseQ <= entBase;
    end
  end

  // Root register with deferred commit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootQ    <= '0;
      pendQ    <= 1'b0;
      pendValQ <= '0;
    end else if (ctl.idle) begin
      if (rootWrEn) begin
        rootQ <= {rootWrData[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        pendQ <= 1'b0;
      end else if (pendQ) begin
        rootQ <= pendValQ;
        pendQ <= 1'b0;
      end
    end else if (rootWrEn) begin
      pendValQ <= {rootWrData[PA_W-1:OFF_W], {OFF_W{1'b0}}};
      pendQ    <= 1'b1;
    end
  end

  // Result registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      paQ    <= '0;
      faultQ <= 1'b0;
      fLvlQ  <= '0;
    end else if (ctl.doneOk) begin
      paQ    <= {entFrame, vaQ[OFF_W-1:0]};
      faultQ <= 1'b0;
      fLvlQ  <= '0;
    end else if (ctl.doneFault) begin
      paQ    <= '0;
      faultQ <= 1'b1;
      fLvlQ  <= lvl;
    end
  end

  // R8
  root_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.idle |=> $stable(rootQ));

  // R3
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (paQ == '0));

  // R6
  user_kernel_never_walks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && usrQ) |-> !vaQ[VA_W-1]);

  // R2
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> (baseQ[OFF_W-1:0] == '0));

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int unsigned LEVELS = PG_LEVELS,
  parameter int unsigned IDX_W  = PG_IDX_W,
  parameter int unsigned OFF_W  = PG_OFF_W,
  parameter int unsigned PA_W   = PG_PA_W,
  parameter int unsigned PTE_W  = PG_PTE_W,
  localparam int unsigned VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rootWrEn,
  input  logic [PA_W-1:0]  rootWrData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspFault,
  output logic [LVL_W-1:0] rspFaultLevel
);

  walkCtl_t         ctl;
  logic [LVL_W-1:0] lvl;
  logic             kernelUser, entryBad, rootPending;

  pgwalk_ctrl #(.LEVELS(LEVELS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .kernelUser  (kernelUser),
    .entryBad    (entryBad),
    .rootPending (rootPending),
    .ctl         (ctl),
    .lvl         (lvl),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid)
  );

  pgwalk_dp #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .lvl           (lvl),
    .rootWrEn      (rootWrEn),
    .rootWrData    (rootWrData),
    .reqVaddr      (reqVaddr),
    .reqWrite      (reqWrite),
    .reqUser       (reqUser),
    .memRspData    (memRspData),
    .kernelUser    (kernelUser),
    .entryBad      (entryBad),
    .rootPending   (rootPending),
    .memReqAddr    (memReqAddr),
    .rspPaddr      (rspPaddr),
    .rspFault      (rspFault),
    .rspFaultLevel (rspFaultLevel)
  );

endmodule

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;

  typedef struct packed {
    logic [47:0] va;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [1:0]  lvl;
    logic [51:0] pa;
    logic [2:0]  reads;
    logic [3:0]  req;
  } vec_t;

  localparam logic [47:0] VA1 = 48'h0000_1234_5678;
  localparam logic [47:0] VA2 = 48'h0000_4020_3ABC;
  localparam logic [47:0] VA3 = 48'h0000_8060_7010;
  localparam logic [47:0] VA4 = 48'h8000_0000_1FFF;
  localparam logic [47:0] VA5 = 48'h0000_C000_0000;
  localparam logic [47:0] VA6 = 48'h0080_0000_0000;
  localparam logic [51:0] ROOT_A = 52'h0_1000;
  localparam logic [51:0] ROOT_B = 52'h4_0000;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{VA1, 1'b0, 1'b1, 1'b0, 2'd0, 52'hABCDE678, 3'd4, 4'd1},  // R1
    '{VA1, 1'b1, 1'b1, 1'b0, 2'd0, 52'hABCDE678, 3'd4, 4'd5},  // R5 allowed
    '{VA2, 1'b0, 1'b1, 1'b0, 2'd0, 52'h55555ABC, 3'd4, 4'd1},  // R1
    '{VA2, 1'b1, 1'b1, 1'b1, 2'd3, 52'h0,        3'd4, 4'd5},  // R5 leaf read-only
    '{VA2, 1'b1, 1'b0, 1'b1, 2'd3, 52'h0,        3'd4, 4'd5},  // R5 supervisor too
    '{VA3, 1'b0, 1'b1, 1'b1, 2'd2, 52'h0,        3'd3, 4'd4},  // R4 user blocked
    '{VA3, 1'b0, 1'b0, 1'b0, 2'd0, 52'h33333010, 3'd4, 4'd4},  // R4 supervisor ok
    '{VA4, 1'b0, 1'b1, 1'b1, 2'd0, 52'h0,        3'd0, 4'd6},  // R6 user kernel
    '{VA4, 1'b0, 1'b0, 1'b0, 2'd0, 52'h77777FFF, 3'd4, 4'd6},  // R6 supervisor
    '{VA5, 1'b0, 1'b0, 1'b1, 2'd1, 52'h0,        3'd2, 4'd3},  // R3 level 1
    '{VA6, 1'b0, 1'b0, 1'b1, 2'd0, 52'h0,        3'd1, 4'd3}   // R3 level 0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootWrEn = 1'b0;
  logic [51:0] rootWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid;
  logic [51:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspFaultLevel;

  always #2 clk = ~clk;

  pgwalk uut (
    .clk(clk), .rstN(rstN), .rootWrEn(rootWrEn), .rootWrData(rootWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .rspFaultLevel(rspFaultLevel)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int readCnt = 0;
  logic [51:0] firstAddr = '0;
  logic [51:0] nextFree = 52'h10_0000;
  logic [63:0] pmem [logic [51:0]];

  function automatic string reqName(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input int rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", reqName(rq), what, act, exp);
    end
  endtask

  function automatic logic [8:0] idxOf(input logic [47:0] va, input int lv);
    return va[12 + 9 * (3 - lv) +: 9];
  endfunction

  // Build a mapping; flg[lv] gives {user, write, present} for a newly made entry.
  task automatic mapPage(input logic [51:0] root, input logic [47:0] va,
                         input logic [39:0] frame, input logic [2:0] flg [4]);
    logic [51:0] base = root;
    for (int lv = 0; lv < 3; lv++) begin
      logic [51:0] a = base + {idxOf(va, lv), 3'b000};
      if (pmem.exists(a) && pmem[a][0]) begin
        base = {pmem[a][51:12], 12'h000};
      end else begin
        pmem[a]  = {12'h000, nextFree[51:12], 9'h000, flg[lv]};
        base     = nextFree;
        nextFree = nextFree + 52'h1000;
      end
    end
    pmem[base + {idxOf(va, 3), 3'b000}] = {12'h000, frame, 9'h000, flg[3]};
  endtask

  // Table memory: answers each read one cycle after it is seen.
  logic        rspPend = 1'b0;
  logic [51:0] rspAddr = '0;
  always @(negedge clk) begin
    if (rspPend) begin
      memRspValid = 1'b1;
      memRspData  = pmem.exists(rspAddr) ? pmem[rspAddr] : 64'h0;
      rspPend     = 1'b0;
    end else begin
      memRspValid = 1'b0;
    end
    if (memReqValid) begin
      if (readCnt == 0) firstAddr = memReqAddr;
      rspPend = 1'b1;
      rspAddr = memReqAddr;
      readCnt++;
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=<50000", cycles);
      finishRun();
    end
  end

  task automatic writeRoot(input logic [51:0] v);
    @(negedge clk);
    rootWrEn = 1'b1; rootWrData = v;
    @(negedge clk);
    rootWrEn = 1'b0;
  endtask

  task automatic waitRsp(output logic f, output logic [1:0] l,
                         output logic [51:0] pa, output int reads);
    int guard = 0;
    while (!rspValid && guard < 100) begin @(negedge clk); guard++; end
    check(9, "response arrives", {63'h0, rspValid}, 64'h1);
    f = rspFault; l = rspFaultLevel; pa = rspPaddr; reads = readCnt;
  endtask

  task automatic translate(input logic [47:0] va, input logic wr, input logic usr,
                           output logic f, output logic [1:0] l,
                           output logic [51:0] pa, output int reads);
    int guard = 0;
    @(negedge clk);
    while (!reqReady && guard < 100) begin @(negedge clk); guard++; end
    readCnt = 0;
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp(f, l, pa, reads);
  endtask

  initial begin
    logic f;
    logic [1:0] l;
    logic [51:0] pa;
    int rd;
    logic [2:0] all7 [4] = '{3'd7, 3'd7, 3'd7, 3'd7};
    logic [2:0] ro    [4] = '{3'd7, 3'd7, 3'd7, 3'd5};
    logic [2:0] supL2 [4] = '{3'd7, 3'd7, 3'd3, 3'd7};
    logic [2:0] kern  [4] = '{3'd3, 3'd3, 3'd3, 3'd3};

    mapPage(ROOT_A, VA1, 40'hABCDE, all7);
    mapPage(ROOT_A, VA2, 40'h55555, ro);
    mapPage(ROOT_A, VA3, 40'h33333, supL2);
    mapPage(ROOT_A, VA4, 40'h77777, kern);
    mapPage(ROOT_B, VA1, 40'h12121, all7);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(10, "reqReady after reset", {63'h0, reqReady}, 64'h1);
    check(10, "memReqValid after reset", {63'h0, memReqValid}, 64'h0);
    check(10, "rspValid after reset", {63'h0, rspValid}, 64'h0);
    // R10 root is zero: an unmapped tree at 0 faults at level 0
    translate(VA1, 1'b0, 1'b0, f, l, pa, rd);
    check(10, "walk from zero root faults", {63'h0, f}, 64'h1);
    check(2, "zero-root first read address", {12'h0, firstAddr}, 64'h0);

    writeRoot(ROOT_A);

    for (int i = 0; i < NVEC; i++) begin
      translate(VECS[i].va, VECS[i].wr, VECS[i].usr, f, l, pa, rd);
      check(VECS[i].req, $sformatf("vec%0d fault", i), {63'h0, f}, {63'h0, VECS[i].flt});
      check(VECS[i].req, $sformatf("vec%0d reads", i), 64'(rd), 64'(VECS[i].reads));
      if (VECS[i].flt)
        check(VECS[i].req, $sformatf("vec%0d level", i), {62'h0, l}, {62'h0, VECS[i].lvl});
      check(VECS[i].req, $sformatf("vec%0d paddr", i), {12'h0, pa}, {12'h0, VECS[i].pa});
    end

    // R2 first read lands at root + index*8 (index 0x100 -> 0x1800)
    translate(VA4, 1'b0, 1'b0, f, l, pa, rd);
    check(2, "first entry address", {12'h0, firstAddr}, 64'h1800);

    // R7 idle root switch redirects later walks
    writeRoot(ROOT_B);
    translate(VA1, 1'b0, 1'b1, f, l, pa, rd);
    check(7, "paddr after root switch", {12'h0, pa}, 64'h12121678);

    // R7 write in the same cycle as acceptance applies to that request
    @(negedge clk);
    readCnt = 0;
    reqValid = 1'b1; reqVaddr = VA1; reqWrite = 1'b0; reqUser = 1'b1;
    rootWrEn = 1'b1; rootWrData = ROOT_A;
    @(negedge clk);
    reqValid = 1'b0; rootWrEn = 1'b0;
    waitRsp(f, l, pa, rd);
    check(7, "same-cycle root write", {12'h0, pa}, 64'hABCDE678);

    // R8 root write during a walk is deferred
    writeRoot(ROOT_B);
    @(negedge clk);
    readCnt = 0;
    reqValid = 1'b1; reqVaddr = VA1; reqWrite = 1'b0; reqUser = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    rootWrEn = 1'b1; rootWrData = ROOT_A;
    @(negedge clk);
    rootWrEn = 1'b0;
    waitRsp(f, l, pa, rd);
    check(8, "walk keeps old root", {12'h0, pa}, 64'h12121678);
    @(negedge clk);
    check(8, "ready held while root pending", {63'h0, reqReady}, 64'h0);
    @(negedge clk);
    check(8, "ready after commit", {63'h0, reqReady}, 64'h1);
    translate(VA1, 1'b0, 1'b1, f, l, pa, rd);
    check(8, "deferred root applied", {12'h0, pa}, 64'hABCDE678);

    // R9 no stray response after the walk
    @(negedge clk);
    check(9, "rspValid drops after result", {63'h0, rspValid}, 64'h0);

    finishRun();
  end

endmodule